// File: doc/BRIEF.md
# Memory Ordering Hazard Detector

This block sits beside the load/store units of an out-of-order core. Every memory operation is entered into a load queue or a store queue when it is dispatched, in program order, and receives an age tag from a shared counter. The entry stays in its queue until the operation retires. Stores stay until they have also been written to the cache. When a store computes its address, the block compares it against the load queue. Any load that is younger than the store, has already executed, and touched the same 8-byte line read stale data. The oldest such load is reported so the core can replay from it.

Each violation also sets one bit in a store-wait table indexed by the offending load's instruction address. At dispatch the block returns that bit as a hint, so a load that once went wrong can wait for older stores. A programmable interval wipes the whole table so that old hints fade. Retired stores leave through a valid/ready cache-write port in program order.

Two small state machines run in the block. The drain sequencer has two states. In DR_IDLE it waits until the oldest store entry is retired, then moves to DR_WRITE. In DR_WRITE it presents that store on the write port and returns to DR_IDLE on the cycle the port accepts it. The table sequencer also has two states. PR_COUNT counts cycles and moves to PR_WIPE when the programmed interval has elapsed. PR_WIPE clears the table and returns to PR_COUNT after one cycle.

Top module: `mdv_order_check`

## Requirements
- R1: After reset both queues are empty, `disp_ready` is 1 for either operation type, `disp_seq` and `disp_idx` are 0, and `replay_valid` and `wr_valid` are 0.
- R2: Each queue accepts up to DEPTH entries. When the queue selected by `disp_is_store` is full, `disp_ready` is 0, and the other queue's readiness is unaffected.
- R3: `disp_seq` gives the age tag for the operation being dispatched. The tag rises by one, modulo 2^SEQ_W, for every accepted dispatch. `disp_idx` gives the slot in the selected queue, and slots are handed out in circular order.
- R4: A store execution whose address falls in the same 8-byte line (address bits above bit 2) as an already executed load with a younger tag raises `replay_valid` for exactly one cycle, on the clock edge after the store execution. `replay_seq` and `replay_pc` carry that load's tag and instruction address. Tags are compared as modular numbers, so ordering stays correct across counter wraparound.
- R5: No replay is raised when the matching load is older than the store, when it has not yet executed, or when it lies in a different 8-byte line.
- R6: When several younger executed loads match, the oldest of them is reported.
- R7: A violation sets the table bit selected by instruction-address bits [PIDX_W+1:2] of the load. From then on, `disp_wait` is 1 whenever `disp_pc` selects that bit.
- R8: With `clr_period` at 0 the table is never wiped. With a nonzero value, the whole table is cleared once every `clr_period`+1 cycles.
- R9: A store is written only after it has retired. Stores drain in program order. `wr_valid`, `wr_addr` and `wr_data` stay constant until `wr_ready`, and `wr_valid` drops on the cycle after acceptance.
- R10: `flush_valid` removes every entry whose tag is equal to or younger than `flush_seq` from both queues and frees their slots. Dispatch is blocked during that cycle, and the next dispatch receives tag `flush_seq`.
- R11: Retiring a load frees the oldest load-queue slot, so `disp_ready` for loads returns after a full queue retires one load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_is_store | input | 1 | 1 selects the store queue, 0 the load queue |
| disp_pc | input | PC_W | Instruction address of the dispatched operation |
| disp_ready | output | 1 | Dispatch can be accepted this cycle |
| disp_seq | output | SEQ_W | Age tag the dispatched operation receives |
| disp_idx | output | IW | Queue slot the dispatched operation receives |
| disp_wait | output | 1 | Store-wait hint for `disp_pc` |
| ld_exec_valid | input | 1 | A load has executed |
| ld_exec_idx | input | IW | Load-queue slot of that load |
| ld_exec_addr | input | AW | Address the load read |
| st_exec_valid | input | 1 | A store has computed its address and data |
| st_exec_idx | input | IW | Store-queue slot of that store |
| st_exec_addr | input | AW | Store address |
| st_exec_data | input | DW | Store data |
| ret_valid | input | 1 | Retire the oldest operation of one type |
| ret_is_store | input | 1 | Type of the retiring operation |
| flush_valid | input | 1 | Discard entries from `flush_seq` onward |
| flush_seq | input | SEQ_W | Oldest tag to discard |
| clr_period | input | CNT_W | Table wipe interval, 0 disables wiping |
| replay_valid | output | 1 | Ordering violation found |
| replay_seq | output | SEQ_W | Tag of the load to replay from |
| replay_pc | output | PC_W | Instruction address of that load |
| wr_valid | output | 1 | Cache write request |
| wr_ready | input | 1 | Cache accepts the write |
| wr_addr | output | AW | Write address |
| wr_data | output | DW | Write data |

## Verification
The bench builds the block with DEPTH 4, a 16-entry table and 4-bit tags. With these values both queues can be filled to their limit in a few cycles. A short run of scenarios also pushes the tag counter through wraparound, so violations are checked across the wrap point. The 16-entry table makes it easy to pick instruction addresses that land in distinct table bits. An 8-bit wipe interval lets one short phase show the table surviving with wiping disabled and then being cleared.

// File: rtl/mdv_pkg.sv
package mdv_pkg;

    typedef enum logic [0:0] {
        DR_IDLE,
        DR_WRITE
    } drain_state_e;

    typedef enum logic [0:0] {
        PR_COUNT,
        PR_WIPE
    } pred_state_e;

    localparam int unsigned LINE_LSB = 3;

endpackage

// File: rtl/mdv_load_q.sv
module mdv_load_q #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned LW    = 29,
    parameter int unsigned PC_W  = 32,
    parameter int unsigned SEQ_W = 7,
    localparam int unsigned IW   = $clog2(DEPTH),
    localparam int unsigned CW   = IW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic [SEQ_W-1:0] alloc_seq,
    input  logic [PC_W-1:0]  alloc_pc,
    output logic             full,
    output logic [IW-1:0]    tail_idx,
    input  logic             exec_valid,
    input  logic [IW-1:0]    exec_idx,
    input  logic [LW-1:0]    exec_line,
    input  logic             retire,
    input  logic             flush,
    input  logic [SEQ_W-1:0] flush_seq,
    input  logic             chk_valid,
    input  logic [SEQ_W-1:0] chk_seq,
    input  logic [LW-1:0]    chk_line,
    output logic             hit,
    output logic [SEQ_W-1:0] hit_seq,
    output logic [PC_W-1:0]  hit_pc
);

    logic [DEPTH-1:0] vld;
    logic [DEPTH-1:0] done;
    logic [SEQ_W-1:0] seq_q  [DEPTH];
    logic [LW-1:0]    line_q [DEPTH];
    logic [PC_W-1:0]  pc_q   [DEPTH];
    logic [IW-1:0]    head;
    logic [IW-1:0]    tail;
    logic [CW-1:0]    cnt;
    logic [CW-1:0]    keep;

    // a is strictly younger than b in modular tag order
    function automatic logic younger(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
        logic [SEQ_W-1:0] d;
        d = a - b;
        return (d != '0) && !d[SEQ_W-1];
    endfunction

    assign full     = (cnt == CW'(DEPTH));
    assign tail_idx = tail;

    // entries older than the flush point survive
    always_comb begin
        keep = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (vld[i] && younger(flush_seq, seq_q[i])) begin
                keep = keep + CW'(1);
            end
        end
    end

    // walk from the head so the first match is the oldest
    always_comb begin
        logic [IW-1:0] j;
        hit     = 1'b0;
        hit_seq = '0;
        hit_pc  = '0;
        for (int k = 0; k < DEPTH; k++) begin
            j = head + IW'(k);
            if (!hit && chk_valid && vld[j] && done[j] &&
                younger(seq_q[j], chk_seq) && (line_q[j] == chk_line)) begin
                hit     = 1'b1;
                hit_seq = seq_q[j];
                hit_pc  = pc_q[j];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld  <= '0;
            done <= '0;
            head <= '0;
            tail <= '0;
            cnt  <= '0;
        end else if (flush) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (vld[i] && !younger(flush_seq, seq_q[i])) begin
                    vld[i]  <= 1'b0;
                    done[i] <= 1'b0;
                end
            end
            tail <= head + keep[IW-1:0];
            cnt  <= keep;
        end else begin
            if (alloc) begin
                vld[tail]  <= 1'b1;
                done[tail] <= 1'b0;
                tail       <= tail + IW'(1);
            end
            if (exec_valid) begin
                done[exec_idx] <= 1'b1;
            end
            if (retire) begin
                vld[head]  <= 1'b0;
                done[head] <= 1'b0;
                head       <= head + IW'(1);
            end
            cnt <= cnt + CW'(alloc) - CW'(retire);
        end
    end

    always_ff @(posedge clk) begin
        if (alloc && !flush) begin
            seq_q[tail] <= alloc_seq;
            pc_q[tail]  <= alloc_pc;
        end
        if (exec_valid && !flush) begin
            line_q[exec_idx] <= exec_line;
        end
    end

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !full);

    p_retire_nonempty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> vld[head]);

    p_exec_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |-> vld[exec_idx]);

endmodule

// File: rtl/mdv_store_q.sv
module mdv_store_q
    import mdv_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned AW    = 32,
    parameter int unsigned DW    = 64,
    parameter int unsigned SEQ_W = 7,
    localparam int unsigned IW   = $clog2(DEPTH),
    localparam int unsigned CW   = IW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic [SEQ_W-1:0] alloc_seq,
    output logic             full,
    output logic [IW-1:0]    tail_idx,
    input  logic             exec_valid,
    input  logic [IW-1:0]    exec_idx,
    input  logic [AW-1:0]    exec_addr,
    input  logic [DW-1:0]    exec_data,
    output logic [SEQ_W-1:0] exec_seq,
    input  logic             retire,
    input  logic             flush,
    input  logic [SEQ_W-1:0] flush_seq,
    output logic             wr_valid,
    input  logic             wr_ready,
    output logic [AW-1:0]    wr_addr,
    output logic [DW-1:0]    wr_data
);

    logic [DEPTH-1:0] vld;
    logic [DEPTH-1:0] done;
    logic [DEPTH-1:0] rtd;
    logic [SEQ_W-1:0] seq_q  [DEPTH];
    logic [AW-1:0]    addr_q [DEPTH];
    logic [DW-1:0]    data_q [DEPTH];
    logic [IW-1:0]    head;
    logic [IW-1:0]    rptr;
    logic [IW-1:0]    tail;
    logic [CW-1:0]    cnt;
    logic [CW-1:0]    keep;
    logic             pop;

    drain_state_e state_q;
    drain_state_e state_d;

    function automatic logic younger(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
        logic [SEQ_W-1:0] d;
        d = a - b;
        return (d != '0) && !d[SEQ_W-1];
    endfunction

    assign full     = (cnt == CW'(DEPTH));
    assign tail_idx = tail;
    assign exec_seq = seq_q[exec_idx];

    always_comb begin
        keep = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (vld[i] && younger(flush_seq, seq_q[i])) begin
                keep = keep + CW'(1);
            end
        end
    end

    // drain sequencer: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // drain sequencer: transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DR_IDLE:  if (vld[head] && rtd[head]) state_d = DR_WRITE;
            DR_WRITE: if (wr_ready)               state_d = DR_IDLE;
            default:                               state_d = DR_IDLE;
        endcase
    end

    // drain sequencer: outputs
    always_comb begin
        wr_valid = 1'b0;
        unique case (state_q)
            DR_IDLE:  wr_valid = 1'b0;
            DR_WRITE: wr_valid = 1'b1;
            default:  wr_valid = 1'b0;
        endcase
    end

    assign wr_addr = addr_q[head];
    assign wr_data = data_q[head];
    assign pop     = wr_valid && wr_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld  <= '0;
            done <= '0;
            rtd  <= '0;
            head <= '0;
            rptr <= '0;
            tail <= '0;
            cnt  <= '0;
        end else if (flush) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (vld[i] && !younger(flush_seq, seq_q[i])) begin
                    vld[i]  <= 1'b0;
                    done[i] <= 1'b0;
                    rtd[i]  <= 1'b0;
                end
            end
            if (pop) begin
                vld[head] <= 1'b0;
                rtd[head] <= 1'b0;
                head      <= head + IW'(1);
            end
            tail <= head + keep[IW-1:0];
            cnt  <= keep - CW'(pop);
        end else begin
            if (alloc) begin
                vld[tail]  <= 1'b1;
                done[tail] <= 1'b0;
                rtd[tail]  <= 1'b0;
                tail       <= tail + IW'(1);
            end
            if (exec_valid) begin
                done[exec_idx] <= 1'b1;
            end
            if (retire) begin
                rtd[rptr] <= 1'b1;
                rptr      <= rptr + IW'(1);
            end
            if (pop) begin
                vld[head]  <= 1'b0;
                done[head] <= 1'b0;
                rtd[head]  <= 1'b0;
                head       <= head + IW'(1);
            end
            cnt <= cnt + CW'(alloc) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (alloc && !flush) begin
            seq_q[tail] <= alloc_seq;
        end
        if (exec_valid && !flush) begin
            addr_q[exec_idx] <= exec_addr;
            data_q[exec_idx] <= exec_data;
        end
    end

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !full);

    p_drain_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    p_retire_executed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> (vld[rptr] && (done[rptr] || (exec_valid && exec_idx == rptr))));

    p_write_retired_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> rtd[head]);

endmodule

// File: rtl/mdv_wait_pred.sv
module mdv_wait_pred
    import mdv_pkg::*;
#(
    parameter int unsigned ENTRIES = 1024,
    parameter int unsigned PC_W    = 32,
    parameter int unsigned CNT_W   = 16,
    localparam int unsigned PIDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  look_pc,
    output logic             look_wait,
    input  logic             train,
    input  logic [PC_W-1:0]  train_pc,
    input  logic [CNT_W-1:0] period
);

    logic [ENTRIES-1:0] tbl;
    logic [CNT_W-1:0]   cnt;
    logic [PIDX_W-1:0]  look_idx;
    logic [PIDX_W-1:0]  train_idx;
    logic               wipe;

    pred_state_e state_q;
    pred_state_e state_d;

    assign look_idx  = look_pc[PIDX_W+1:2];
    assign train_idx = train_pc[PIDX_W+1:2];
    assign look_wait = tbl[look_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PR_COUNT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PR_COUNT: if ((period != '0) && (cnt >= period - CNT_W'(1))) state_d = PR_WIPE;
            PR_WIPE:  state_d = PR_COUNT;
            default:  state_d = PR_COUNT;
        endcase
    end

    always_comb begin
        wipe = 1'b0;
        unique case (state_q)
            PR_COUNT: wipe = 1'b0;
            PR_WIPE:  wipe = 1'b1;
            default:  wipe = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if ((state_q != PR_COUNT) || (state_d == PR_WIPE) || (period == '0)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // a training write in the wipe cycle survives the wipe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl <= '0;
        end else begin
            if (wipe) begin
                tbl <= '0;
            end
            if (train) begin
                tbl[train_idx] <= 1'b1;
            end
        end
    end

    p_train_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        train |=> tbl[$past(train_idx)]);

    p_wipe_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wipe && !train) |=> (tbl == '0));

endmodule

// File: rtl/mdv_order_check.sv
module mdv_order_check #(
    parameter int unsigned DEPTH        = 32,
    parameter int unsigned AW           = 32,
    parameter int unsigned DW           = 64,
    parameter int unsigned PC_W         = 32,
    parameter int unsigned PRED_ENTRIES = 1024,
    parameter int unsigned CNT_W        = 16,
    localparam int unsigned IW          = $clog2(DEPTH),
    localparam int unsigned SEQ_W       = IW + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_valid,
    input  logic             disp_is_store,
    input  logic [PC_W-1:0]  disp_pc,
    output logic             disp_ready,
    output logic [SEQ_W-1:0] disp_seq,
    output logic [IW-1:0]    disp_idx,
    output logic             disp_wait,
    input  logic             ld_exec_valid,
    input  logic [IW-1:0]    ld_exec_idx,
    input  logic [AW-1:0]    ld_exec_addr,
    input  logic             st_exec_valid,
    input  logic [IW-1:0]    st_exec_idx,
    input  logic [AW-1:0]    st_exec_addr,
    input  logic [DW-1:0]    st_exec_data,
    input  logic             ret_valid,
    input  logic             ret_is_store,
    input  logic             flush_valid,
    input  logic [SEQ_W-1:0] flush_seq,
    input  logic [CNT_W-1:0] clr_period,
    output logic             replay_valid,
    output logic [SEQ_W-1:0] replay_seq,
    output logic [PC_W-1:0]  replay_pc,
    output logic             wr_valid,
    input  logic             wr_ready,
    output logic [AW-1:0]    wr_addr,
    output logic [DW-1:0]    wr_data
);
    import mdv_pkg::*;

    localparam int unsigned LW = AW - LINE_LSB;

    logic             accept;
    logic             lq_full;
    logic             sq_full;
    logic [IW-1:0]    lq_tail;
    logic [IW-1:0]    sq_tail;
    logic [SEQ_W-1:0] seq_q;
    logic [SEQ_W-1:0] st_seq;
    logic             viol;
    logic [SEQ_W-1:0] viol_seq;
    logic [PC_W-1:0]  viol_pc;
    logic             ld_ex;
    logic             st_ex;

    assign disp_ready = !flush_valid && (disp_is_store ? !sq_full : !lq_full);
    assign accept     = disp_valid && disp_ready;
    assign disp_seq   = seq_q;
    assign disp_idx   = disp_is_store ? sq_tail : lq_tail;
    assign ld_ex      = ld_exec_valid && !flush_valid;
    assign st_ex      = st_exec_valid && !flush_valid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else if (flush_valid) begin
            seq_q <= flush_seq;
        end else if (accept) begin
            seq_q <= seq_q + SEQ_W'(1);
        end
    end

    mdv_load_q #(
        .DEPTH (DEPTH),
        .LW    (LW),
        .PC_W  (PC_W),
        .SEQ_W (SEQ_W)
    ) u_lq (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc      (accept && !disp_is_store),
        .alloc_seq  (seq_q),
        .alloc_pc   (disp_pc),
        .full       (lq_full),
        .tail_idx   (lq_tail),
        .exec_valid (ld_ex),
        .exec_idx   (ld_exec_idx),
        .exec_line  (ld_exec_addr[AW-1:LINE_LSB]),
        .retire     (ret_valid && !ret_is_store && !flush_valid),
        .flush      (flush_valid),
        .flush_seq  (flush_seq),
        .chk_valid  (st_ex),
        .chk_seq    (st_seq),
        .chk_line   (st_exec_addr[AW-1:LINE_LSB]),
        .hit        (viol),
        .hit_seq    (viol_seq),
        .hit_pc     (viol_pc)
    );

    mdv_store_q #(
        .DEPTH (DEPTH),
        .AW    (AW),
        .DW    (DW),
        .SEQ_W (SEQ_W)
    ) u_sq (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc      (accept && disp_is_store),
        .alloc_seq  (seq_q),
        .full       (sq_full),
        .tail_idx   (sq_tail),
        .exec_valid (st_ex),
        .exec_idx   (st_exec_idx),
        .exec_addr  (st_exec_addr),
        .exec_data  (st_exec_data),
        .exec_seq   (st_seq),
        .retire     (ret_valid && ret_is_store && !flush_valid),
        .flush      (flush_valid),
        .flush_seq  (flush_seq),
        .wr_valid   (wr_valid),
        .wr_ready   (wr_ready),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );

    mdv_wait_pred #(
        .ENTRIES (PRED_ENTRIES),
        .PC_W    (PC_W),
        .CNT_W   (CNT_W)
    ) u_pred (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_pc   (disp_pc),
        .look_wait (disp_wait),
        .train     (viol),
        .train_pc  (viol_pc),
        .period    (clr_period)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            replay_valid <= 1'b0;
            replay_seq   <= '0;
            replay_pc    <= '0;
        end else begin
            replay_valid <= viol;
            if (viol) begin
                replay_seq <= viol_seq;
                replay_pc  <= viol_pc;
            end
        end
    end

    p_seq_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !flush_valid) |=> (disp_seq == $past(disp_seq) + SEQ_W'(1)));

    p_flush_seq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> (disp_seq == $past(flush_seq)));

    p_flush_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> !disp_ready);

    p_replay_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        replay_valid |-> $past(st_exec_valid));

endmodule

// File: tb/tb_mdv_order_check.sv
module tb_mdv_order_check;

    localparam int DEPTH = 4;
    localparam int AW    = 16;
    localparam int DW    = 32;
    localparam int PC_W  = 16;
    localparam int NPRED = 16;
    localparam int CNT_W = 8;
    localparam int IW    = 2;
    localparam int SEQ_W = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             disp_valid, disp_is_store;
    logic [PC_W-1:0]  disp_pc;
    logic             disp_ready, disp_wait;
    logic [SEQ_W-1:0] disp_seq;
    logic [IW-1:0]    disp_idx;
    logic             ld_exec_valid, st_exec_valid;
    logic [IW-1:0]    ld_exec_idx, st_exec_idx;
    logic [AW-1:0]    ld_exec_addr, st_exec_addr;
    logic [DW-1:0]    st_exec_data;
    logic             ret_valid, ret_is_store, flush_valid;
    logic [SEQ_W-1:0] flush_seq;
    logic [CNT_W-1:0] clr_period;
    logic             replay_valid;
    logic [SEQ_W-1:0] replay_seq;
    logic [PC_W-1:0]  replay_pc;
    logic             wr_valid, wr_ready;
    logic [AW-1:0]    wr_addr;
    logic [DW-1:0]    wr_data;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    mdv_order_check #(
        .DEPTH(DEPTH), .AW(AW), .DW(DW), .PC_W(PC_W),
        .PRED_ENTRIES(NPRED), .CNT_W(CNT_W)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_is_store(disp_is_store), .disp_pc(disp_pc),
        .disp_ready(disp_ready), .disp_seq(disp_seq), .disp_idx(disp_idx), .disp_wait(disp_wait),
        .ld_exec_valid(ld_exec_valid), .ld_exec_idx(ld_exec_idx), .ld_exec_addr(ld_exec_addr),
        .st_exec_valid(st_exec_valid), .st_exec_idx(st_exec_idx), .st_exec_addr(st_exec_addr),
        .st_exec_data(st_exec_data),
        .ret_valid(ret_valid), .ret_is_store(ret_is_store),
        .flush_valid(flush_valid), .flush_seq(flush_seq), .clr_period(clr_period),
        .replay_valid(replay_valid), .replay_seq(replay_seq), .replay_pc(replay_pc),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    typedef struct packed {
        logic [15:0] st_addr;
        logic [15:0] ld_addr;
        logic        ld_first;
        logic        exp_hit;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{16'h0100, 16'h0100, 1'b1, 1'b1},
        '{16'h0100, 16'h0104, 1'b1, 1'b1},
        '{16'h0100, 16'h0108, 1'b1, 1'b0},
        '{16'h0100, 16'h0100, 1'b0, 1'b0},
        '{16'h02F8, 16'h02FF, 1'b1, 1'b1},
        '{16'h02F8, 16'h0300, 1'b1, 1'b0},
        '{16'hFFF8, 16'hFFF8, 1'b0, 1'b0},
        '{16'h0040, 16'h0047, 1'b1, 1'b1},
        '{16'h0800, 16'h0800, 1'b1, 1'b1},
        '{16'h0800, 16'h0805, 1'b1, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic dispatch(input logic st, input logic [PC_W-1:0] pc,
                            output logic [SEQ_W-1:0] seq, output logic [IW-1:0] idx);
        disp_valid = 1'b1; disp_is_store = st; disp_pc = pc;
        #1;
        seq = disp_seq; idx = disp_idx;
        step();
        disp_valid = 1'b0;
    endtask

    task automatic exec_ld(input logic [IW-1:0] idx, input logic [AW-1:0] a);
        ld_exec_valid = 1'b1; ld_exec_idx = idx; ld_exec_addr = a;
        step();
        ld_exec_valid = 1'b0;
    endtask

    task automatic exec_st(input logic [IW-1:0] idx, input logic [AW-1:0] a, input logic [DW-1:0] d);
        st_exec_valid = 1'b1; st_exec_idx = idx; st_exec_addr = a; st_exec_data = d;
        step();
        st_exec_valid = 1'b0;
    endtask

    task automatic flush_at(input logic [SEQ_W-1:0] s);
        flush_valid = 1'b1; flush_seq = s;
        step();
        flush_valid = 1'b0;
    endtask

    task automatic retire(input logic st);
        ret_valid = 1'b1; ret_is_store = st;
        step();
        ret_valid = 1'b0;
    endtask

    task automatic drain(input string req, input logic [AW-1:0] a, input logic [DW-1:0] d);
        for (int k = 0; k < 10 && !wr_valid; k++) step();
        check(req, wr_valid, 1'b1);
        check(req, wr_addr, a);
        check(req, wr_data, d);
        wr_ready = 1'b1;
        step();
        wr_ready = 1'b0;
        check(req, wr_valid, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        report();
    end

    initial begin
        logic [SEQ_W-1:0] s0, s1, s2, s3, sx;
        logic [IW-1:0]    i0, i1, i2, i3, ix;
        rst_n = 1'b0;
        disp_valid = 0; disp_is_store = 0; disp_pc = '0;
        ld_exec_valid = 0; ld_exec_idx = '0; ld_exec_addr = '0;
        st_exec_valid = 0; st_exec_idx = '0; st_exec_addr = '0; st_exec_data = '0;
        ret_valid = 0; ret_is_store = 0; flush_valid = 0; flush_seq = '0;
        clr_period = '0; wr_ready = 0;
        repeat (3) step();
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 ready ld", disp_ready, 1'b1);
        disp_is_store = 1'b1; #1;
        check("R1 ready st", disp_ready, 1'b1);
        check("R1 seq", disp_seq, 0);
        check("R1 idx", disp_idx, 0);
        check("R1 replay", replay_valid, 1'b0);
        check("R1 wr", wr_valid, 1'b0);
        step();

        // R2 / R3 / R11: fill the load queue
        for (int k = 0; k < DEPTH; k++) begin
            dispatch(1'b0, 16'h1000, sx, ix);
            check("R3 seq", sx, k);
            check("R3 idx", ix, k);
        end
        disp_is_store = 1'b0; #1;
        check("R2 ld full", disp_ready, 1'b0);
        disp_is_store = 1'b1; #1;
        check("R2 st free", disp_ready, 1'b1);
        retire(1'b0);
        disp_is_store = 1'b0; #1;
        check("R11 ld freed", disp_ready, 1'b1);
        for (int k = 0; k < DEPTH - 1; k++) retire(1'b0);

        // R2 / R10: fill the store queue, then flush it
        for (int k = 0; k < DEPTH; k++) dispatch(1'b1, 16'h1000, sx, ix);
        disp_is_store = 1'b1; #1;
        check("R2 st full", disp_ready, 1'b0);
        flush_at(4'd4);
        #1;
        check("R10 st freed", disp_ready, 1'b1);
        check("R10 seq restart", disp_seq, 4);

        // R9: no write before retirement, then hold until accepted
        dispatch(1'b1, 16'h1100, s0, i0);
        exec_st(i0, 16'h1238, 32'hCAFE0001);
        repeat (3) step();
        check("R9 no early write", wr_valid, 1'b0);
        retire(1'b1);
        for (int k = 0; k < 10 && !wr_valid; k++) step();
        check("R9 write", wr_valid, 1'b1);
        repeat (3) step();
        check("R9 hold valid", wr_valid, 1'b1);
        check("R9 hold addr", wr_addr, 16'h1238);
        drain("R9 drain", 16'h1238, 32'hCAFE0001);

        // R6 / R7 / R10: several younger matching loads
        dispatch(1'b1, 16'h1200, s0, i0);
        dispatch(1'b0, 16'h2000, s1, i1);
        dispatch(1'b0, 16'h2004, s2, i2);
        dispatch(1'b0, 16'h2008, s3, i3);
        check("R3 step", s3, s0 + 4'd3);
        exec_ld(i1, 16'h0500);
        exec_ld(i2, 16'h0440);
        exec_ld(i3, 16'h0444);
        exec_st(i0, 16'h0440, 32'hBEEF0002);
        check("R6 replay", replay_valid, 1'b1);
        check("R6 oldest seq", replay_seq, s2);
        check("R6 oldest pc", replay_pc, 16'h2004);
        step();
        check("R4 single pulse", replay_valid, 1'b0);
        disp_pc = 16'h2004; #1;
        check("R7 trained", disp_wait, 1'b1);
        disp_pc = 16'h2008; #1;
        check("R7 untrained", disp_wait, 1'b0);
        flush_at(s2);
        #1;
        check("R10 seq", disp_seq, s2);
        for (int k = 0; k < DEPTH - 1; k++) dispatch(1'b0, 16'h2100, sx, ix);
        disp_is_store = 1'b0; #1;
        check("R10 ld count", disp_ready, 1'b0);
        flush_at(s1);
        retire(1'b1);
        drain("R9 drain2", 16'h0440, 32'hBEEF0002);

        // R8: table survives with wiping off, cleared with it on
        repeat (30) step();
        disp_pc = 16'h2004; #1;
        check("R8 no wipe", disp_wait, 1'b1);
        clr_period = 8'd4;
        repeat (12) step();
        clr_period = 8'd0;
        #1;
        check("R8 wiped", disp_wait, 1'b0);

        // R4 / R5 / R9: vector table, tags wrap along the way
        for (int v = 0; v < 10; v++) begin
            dispatch(1'b1, 16'h3100, s0, i0);
            dispatch(1'b0, 16'(16'h3000 + v * 4), s1, i1);
            if (VECS[v].ld_first) begin
                exec_ld(i1, VECS[v].ld_addr);
                exec_st(i0, VECS[v].st_addr, 32'(v + 32'h5000));
            end else begin
                exec_st(i0, VECS[v].st_addr, 32'(v + 32'h5000));
            end
            if (VECS[v].exp_hit) begin
                check("R4 replay", replay_valid, 1'b1);
                check("R4 seq", replay_seq, s1);
                check("R4 pc", replay_pc, 16'(16'h3000 + v * 4));
            end else begin
                check("R5 no replay", replay_valid, 1'b0);
            end
            if (!VECS[v].ld_first) exec_ld(i1, VECS[v].ld_addr);
            flush_at(s1);
            retire(1'b1);
            drain("R9 row", VECS[v].st_addr, 32'(v + 32'h5000));
        end

        report();
    end

endmodule